// File: doc/BRIEF.md
# DMA Channel Status and Byte-Count Register

This block keeps the status and the remaining byte count of one channel of a simple DMA engine. Software reaches it as one 32-bit word. A write with bit 24 clear programs the byte count. A write with bit 24 set acknowledges the channel: it clears every status flag and, if a transfer is running, aborts it. A read returns the flags, the count, and a fixed pattern in the upper count bits once a legal count has been stored.

When the datapath raises a start, the block checks the programmed configuration: size codes, the alignment of the addresses and of the count, the address regions, and a zero count. A bad configuration raises a configuration error and ends the channel at once. A good one makes the channel busy. Each completed write beat then lowers the count by the destination size. A bus error on the read or the write phase ends the channel early. An interrupt line follows the done flag when the channel's interrupt enable is high.

Top module: `dma_chan_stat`

## Requirements
- R1: After reset the readback word is 0x00000000 and `irq` is low.
- R2: The readback word is {0, CE, SRCERR, DSTERR, 0, REQ, BUSY, DONE, PAT[3:0], COUNT[19:0]}, with bits 31 and 27 always zero. PAT reads 0000 until the first legal count write and 1110 from then on.
- R3: A write with bit 24 clear and bits 23..20 all zero loads the count from bits 19..0. If any of bits 23..20 is set, CE rises and the count is left unchanged.
- R4: A start while the channel is idle and the count is zero sets CE and DONE and leaves BUSY low.
- R5: Size codes are 0 for 1 byte, 1 for 2 bytes, 2 for 4 bytes, and 3 for unsupported. A start sets CE and DONE if either code is 3, if the source or the destination address is not a multiple of its own size, or if the count is not a multiple of the larger size.
- R6: A start sets CE and DONE if bits 31..20 of the source or the destination address do not match one of the region tags (by default 0x000, 0x1FF and 0x200).
- R7: A start with a good configuration sets BUSY and clears DONE. REQ is high while BUSY is set and `chan_sel` is low, and drops in the cycle after `chan_sel` rises.
- R8: While BUSY, each `beat_done` pulse lowers the count by the destination size. When the count reaches zero, BUSY and REQ clear and DONE sets. Beats while idle leave the count unchanged, and the count never wraps.
- R9: While BUSY, `rd_err` sets SRCERR and `wr_err` sets DSTERR. Either one ends the channel with DONE set, and the count is not lowered by a beat in the same cycle.
- R10: A write with bit 24 set clears DONE, CE, SRCERR and DSTERR, aborts a busy channel, and leaves the count unchanged. A write with bit 24 clear leaves all flags as they were.
- R11: When an acknowledge write falls in the same cycle as a final beat or a bus error, the flags that the event sets survive and the older flags are cleared.
- R12: `irq` is registered. It rises in the same edge that sets DONE while `irq_en` is high, and it follows `irq_en` one cycle later.
- R13: A count write while BUSY is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Readback word |
| src_addr | input | 32 | Programmed source address |
| dst_addr | input | 32 | Programmed destination address |
| src_size | input | 2 | Source size code |
| dst_size | input | 2 | Destination size code |
| start | input | 1 | Start request pulse |
| chan_sel | input | 1 | Bus master is serving this channel |
| beat_done | input | 1 | One write beat completed |
| rd_err | input | 1 | Bus error on the read phase |
| wr_err | input | 1 | Bus error on the write phase |
| irq_en | input | 1 | Channel interrupt enable |
| irq | output | 1 | Interrupt request |

## Verification
Two functions can land in the same cycle: the software acknowledge write, and a hardware end event (the final beat or a bus error). The bench drives the acknowledge write and the final `beat_done` in the same cycle, and does the same with `rd_err`. It then checks that DONE and the new error flag are set while the flags that were already set are gone. A near-exhaustive sweep of all size codes and address offsets compares the start decision against an alignment rule computed in the bench.

// File: rtl/dcs_pkg.sv
package dcs_pkg;

  typedef enum logic [1:0] {
    SZ_B1  = 2'd0,
    SZ_B2  = 2'd1,
    SZ_B4  = 2'd2,
    SZ_BAD = 2'd3
  } xfer_size_e;

  // status bit positions decoded by software
  localparam int BIT_CE   = 30;
  localparam int BIT_SERR = 29;
  localparam int BIT_DERR = 28;
  localparam int BIT_REQ  = 26;
  localparam int BIT_BUSY = 25;
  localparam int BIT_DONE = 24;

  function automatic logic [2:0] size_bytes(input logic [1:0] code);
    case (xfer_size_e'(code))
      SZ_B1:   size_bytes = 3'd1;
      SZ_B2:   size_bytes = 3'd2;
      SZ_B4:   size_bytes = 3'd4;
      default: size_bytes = 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/dcs_cfg_check.sv
module dcs_cfg_check #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 20,
  parameter int TAG_W  = 12,
  parameter int NREG   = 3,
  parameter logic [NREG*TAG_W-1:0] REGION_TAGS = 36'h200_1FF_000
) (
  input  logic [ADDR_W-1:0] src_addr,
  input  logic [ADDR_W-1:0] dst_addr,
  input  logic [1:0]        src_size,
  input  logic [1:0]        dst_size,
  input  logic [CNT_W-1:0]  cnt,
  output logic              bad
);
  import dcs_pkg::*;

  logic [NREG-1:0] src_hit, dst_hit;

  for (genvar g = 0; g < NREG; g++) begin : g_region
    assign src_hit[g] = src_addr[ADDR_W-1 -: TAG_W] == REGION_TAGS[g*TAG_W +: TAG_W];
    assign dst_hit[g] = dst_addr[ADDR_W-1 -: TAG_W] == REGION_TAGS[g*TAG_W +: TAG_W];
  end

  logic [2:0] sb, db;
  logic [1:0] smask, dmask, mmask;
  logic       size_bad, src_mis, dst_mis, cnt_mis, cnt_zero, region_bad;

  always_comb begin
    sb         = size_bytes(src_size);
    db         = size_bytes(dst_size);
    smask      = sb[1:0] - 2'd1;
    dmask      = db[1:0] - 2'd1;
    mmask      = smask | dmask;
    size_bad   = (src_size == SZ_BAD) || (dst_size == SZ_BAD);
    src_mis    = (src_addr & ADDR_W'(smask)) != '0;
    dst_mis    = (dst_addr & ADDR_W'(dmask)) != '0;
    cnt_mis    = (cnt & CNT_W'(mmask)) != '0;
    cnt_zero   = cnt == '0;
    region_bad = ~|src_hit || ~|dst_hit;
    bad        = size_bad | src_mis | dst_mis | cnt_mis | cnt_zero | region_bad;
  end

endmodule

// File: rtl/dcs_byte_counter.sv
module dcs_byte_counter #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  input  logic [2:0]       dec_by,
  output logic [CNT_W-1:0] cnt,
  output logic             last
);

  logic [CNT_W-1:0] step;
  assign step = CNT_W'(dec_by);
  assign last = cnt <= step;

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (load) cnt <= load_val;
    else if (dec)  cnt <= last ? '0 : cnt - step;
  end

  // R8: a beat can only lower the count, never wrap it upward
  a_r8_no_wrap: assert property (@(posedge clk) disable iff (rst)
    dec && !load |=> cnt <= $past(cnt));

endmodule

// File: rtl/dma_chan_stat.sv
module dma_chan_stat #(
  parameter int ADDR_W = 32,
  parameter int BCR_W  = 24,
  parameter int CNT_W  = 20,
  parameter int TAG_W  = 12,
  parameter int NREG   = 3,
  parameter logic [NREG*TAG_W-1:0] REGION_TAGS = 36'h200_1FF_000,
  parameter logic [3:0] UPPER_PAT = 4'b1110
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [ADDR_W-1:0] src_addr,
  input  logic [ADDR_W-1:0] dst_addr,
  input  logic [1:0]        src_size,
  input  logic [1:0]        dst_size,
  input  logic              start,
  input  logic              chan_sel,
  input  logic              beat_done,
  input  logic              rd_err,
  input  logic              wr_err,
  input  logic              irq_en,
  output logic              irq
);
  import dcs_pkg::*;

  localparam int PAT_W = BCR_W - CNT_W;

  logic ce_q, serr_q, derr_q, req_q, busy_q, done_q, pat_q, irq_q;
  logic [1:0] dsz_q;
  logic [CNT_W-1:0] cnt;
  logic cnt_last, cfg_bad;

  logic clr, cnt_wr, cnt_legal, load, start_ok, start_bad, dec, err_end, fin;
  logic ce_n, serr_n, derr_n, req_n, busy_n, done_n;
  logic unused_wbits;

  assign unused_wbits = ^reg_wdata[31:BIT_DONE+1];

  dcs_cfg_check #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .TAG_W(TAG_W),
    .NREG(NREG), .REGION_TAGS(REGION_TAGS)
  ) u_cfg (
    .src_addr(src_addr), .dst_addr(dst_addr),
    .src_size(src_size), .dst_size(dst_size),
    .cnt(cnt), .bad(cfg_bad)
  );

  dcs_byte_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst),
    .load(load), .load_val(reg_wdata[CNT_W-1:0]),
    .dec(dec), .dec_by(size_bytes(dsz_q)),
    .cnt(cnt), .last(cnt_last)
  );

  always_comb begin
    clr       = reg_wr & reg_wdata[BIT_DONE];
    cnt_wr    = reg_wr & ~reg_wdata[BIT_DONE] & ~busy_q;
    cnt_legal = reg_wdata[BCR_W-1:CNT_W] == '0;
    load      = cnt_wr & cnt_legal;
    start_ok  = start & ~busy_q & ~cfg_bad;
    start_bad = start & ~busy_q & cfg_bad;
    err_end   = busy_q & (rd_err | wr_err);
    dec       = busy_q & beat_done & ~rd_err & ~wr_err;
    fin       = dec & cnt_last;
    // acknowledge clears first; hardware events set on top of it
    ce_n      = (ce_q & ~clr) | (cnt_wr & ~cnt_legal) | start_bad;
    serr_n    = (serr_q & ~clr) | (busy_q & rd_err);
    derr_n    = (derr_q & ~clr) | (busy_q & wr_err);
    done_n    = (done_q & ~clr & ~start_ok) | fin | err_end | start_bad;
    busy_n    = start_ok | (busy_q & ~clr & ~fin & ~err_end);
    req_n     = busy_n & ~chan_sel;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ce_q   <= 1'b0;
      serr_q <= 1'b0;
      derr_q <= 1'b0;
      req_q  <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      pat_q  <= 1'b0;
      irq_q  <= 1'b0;
      dsz_q  <= 2'd0;
    end else begin
      ce_q   <= ce_n;
      serr_q <= serr_n;
      derr_q <= derr_n;
      req_q  <= req_n;
      busy_q <= busy_n;
      done_q <= done_n;
      pat_q  <= pat_q | load;
      irq_q  <= done_n & irq_en;
      if (start_ok) dsz_q <= dst_size;
    end
  end

  assign reg_rdata = {1'b0, ce_q, serr_q, derr_q, 1'b0, req_q, busy_q, done_q,
                      (pat_q ? UPPER_PAT[PAT_W-1:0] : {PAT_W{1'b0}}), cnt};
  assign irq = irq_q;

  // R7: a pending request only exists on a busy channel
  a_r7_req_needs_busy: assert property (@(posedge clk) disable iff (rst)
    req_q |-> busy_q);

  // R8: a channel is never busy and done at once
  a_r8_busy_done_excl: assert property (@(posedge clk) disable iff (rst)
    !(busy_q && done_q));

  // R4 R5 R6: a rejected start ends the channel with an error
  a_r5_bad_start: assert property (@(posedge clk) disable iff (rst)
    start && !busy_q && cfg_bad |=> ce_q && done_q && !busy_q);

  // R10: an acknowledge on an idle channel leaves every flag clear
  a_r10_ack_clears: assert property (@(posedge clk) disable iff (rst)
    reg_wr && reg_wdata[BIT_DONE] && !busy_q && !start
      |=> !ce_q && !serr_q && !derr_q && !done_q);

  // R12: the interrupt line is never up without done
  a_r12_irq_done: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> done_q);

endmodule

// File: tb/dma_chan_stat_tb.sv
module dma_chan_stat_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] src_addr = 32'h0000_1000;
  logic [31:0] dst_addr = 32'h2000_0000;
  logic [1:0]  src_size = 2'd0;
  logic [1:0]  dst_size = 2'd0;
  logic start = 1'b0, chan_sel = 1'b0, beat_done = 1'b0;
  logic rd_err = 1'b0, wr_err = 1'b0, irq_en = 1'b0;
  logic irq;

  int n_chk = 0;
  int n_bad = 0;
  bit ended = 1'b0;

  always #4 clk = ~clk;

  dma_chan_stat u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .src_addr(src_addr), .dst_addr(dst_addr),
    .src_size(src_size), .dst_size(dst_size), .start(start),
    .chan_sel(chan_sel), .beat_done(beat_done), .rd_err(rd_err),
    .wr_err(wr_err), .irq_en(irq_en), .irq(irq)
  );

  localparam logic [31:0] ACK = 32'h0100_0000;

  function automatic logic [31:0] ew(bit ce, bit se, bit de, bit rq,
                                     bit bz, bit dn, bit pat, int cnt);
    ew = {1'b0, ce, se, de, 1'b0, rq, bz, dn, (pat ? 4'hE : 4'h0), cnt[19:0]};
  endfunction

  function automatic int amask(int s);
    amask = (s == 1) ? 1 : (s == 2) ? 3 : 0;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(logic [31:0] v);
    reg_wr = 1'b1; reg_wdata = v; step(); reg_wr = 1'b0;
  endtask

  task automatic go();
    start = 1'b1; step(); start = 1'b0;
  endtask

  task automatic beat();
    beat_done = 1'b1; step(); beat_done = 1'b0;
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    step(); step(); rst = 1'b0; step();
    // R1
    chk("R1 readback", reg_rdata, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);

    // R3 R2: illegal count write before any legal one
    wr(32'h0010_0000);
    chk("R3 illegal count", reg_rdata, ew(1,0,0,0,0,0,0,0));
    wr(ACK);
    chk("R10 ack", reg_rdata, ew(0,0,0,0,0,0,0,0));
    wr(32'h000F_FFFF);
    chk("R2 R3 legal max", reg_rdata, ew(0,0,0,0,0,0,1,20'hFFFFF));
    wr(32'h00F0_0010);
    chk("R3 illegal keeps count", reg_rdata, ew(1,0,0,0,0,0,1,20'hFFFFF));
    wr(ACK);
    chk("R10 ack keeps count", reg_rdata, ew(0,0,0,0,0,0,1,20'hFFFFF));

    // R4 with R12
    wr(32'h0);
    irq_en = 1'b1;
    go();
    chk("R4 zero count start", reg_rdata, ew(1,0,0,0,0,1,1,0));
    chk("R12 irq with done", {31'b0, irq}, 32'h1);
    irq_en = 1'b0; step();
    chk("R12 irq follows enable", {31'b0, irq}, 32'h0);
    wr(ACK);

    // R5 sweep over size codes and address offsets
    for (int ss = 0; ss < 4; ss++)
      for (int ds = 0; ds < 4; ds++)
        for (int so = 0; so < 4; so++)
          for (int dof = 0; dof < 4; dof++) begin
            bit bad;
            src_size = ss[1:0]; dst_size = ds[1:0];
            src_addr = 32'h0000_1000 + so;
            dst_addr = 32'h2000_0000 + dof;
            wr(32'h8);
            go();
            bad = (ss == 3) || (ds == 3) || ((so & amask(ss)) != 0) ||
                  ((dof & amask(ds)) != 0);
            if (bad) chk("R5 rejected start", reg_rdata, ew(1,0,0,0,0,1,1,8));
            else     chk("R7 accepted start", reg_rdata, ew(0,0,0,1,1,0,1,8));
            wr(ACK);
            chk("R10 ack after start", reg_rdata, ew(0,0,0,0,0,0,1,8));
          end

    // R5 count alignment to the larger size
    src_addr = 32'h0000_1000; dst_addr = 32'h2000_0000;
    src_size = 2'd2; dst_size = 2'd0;
    wr(32'h6); go();
    chk("R5 count misaligned", reg_rdata, ew(1,0,0,0,0,1,1,6));
    wr(ACK);
    src_size = 2'd1;
    wr(32'h6); go();
    chk("R5 count aligned", reg_rdata, ew(0,0,0,1,1,0,1,6));
    wr(ACK);

    // R6 regions
    src_size = 2'd0; dst_size = 2'd0;
    src_addr = 32'h4000_0000;
    wr(32'h4); go();
    chk("R6 src region", reg_rdata, ew(1,0,0,0,0,1,1,4));
    wr(ACK);
    src_addr = 32'h0000_1000; dst_addr = 32'h7FF0_0000;
    go();
    chk("R6 dst region", reg_rdata, ew(1,0,0,0,0,1,1,4));
    wr(ACK);
    dst_addr = 32'h1FF0_0000;
    go();
    chk("R6 third region", reg_rdata, ew(0,0,0,1,1,0,1,4));
    wr(ACK);
    dst_addr = 32'h2000_0000;

    // R7 R8 transfers for each destination size
    for (int ds = 0; ds < 3; ds++) begin
      int b, rem;
      b = 1 << ds;
      dst_size = ds[1:0]; src_size = 2'd0;
      wr(32'd12); go();
      chk("R7 req while unselected", reg_rdata, ew(0,0,0,1,1,0,1,12));
      chan_sel = 1'b1; step();
      chk("R7 req drops on select", reg_rdata, ew(0,0,0,0,1,0,1,12));
      rem = 12;
      while (rem > 0) begin
        beat();
        rem -= b;
        if (rem == 0) chk("R8 final beat", reg_rdata, ew(0,0,0,0,0,1,1,0));
        else          chk("R8 beat step", reg_rdata, ew(0,0,0,0,1,0,1,rem));
      end
      beat();
      chk("R8 idle beat no wrap", reg_rdata, ew(0,0,0,0,0,1,1,0));
      chan_sel = 1'b0;
      wr(ACK);
    end

    // R7: a good start clears a leftover done
    dst_size = 2'd0;
    wr(32'd1); go(); beat();
    chk("R8 one byte done", reg_rdata, ew(0,0,0,0,0,1,1,0));
    wr(32'd3); go();
    chk("R7 start clears done", reg_rdata, ew(0,0,0,1,1,0,1,3));

    // R13: count write while busy ignored
    wr(32'h20);
    chk("R13 write while busy", reg_rdata, ew(0,0,0,1,1,0,1,3));

    // R9: read error with a beat in the same cycle
    beat_done = 1'b1; rd_err = 1'b1; step(); beat_done = 1'b0; rd_err = 1'b0;
    chk("R9 read error", reg_rdata, ew(0,1,0,0,0,1,1,3));
    // R10: write with bit 24 clear leaves flags
    wr(32'h4);
    chk("R10 plain write keeps flags", reg_rdata, ew(0,1,0,0,0,1,1,4));
    wr(ACK);
    go(); beat();
    wr_err = 1'b1; step(); wr_err = 1'b0;
    chk("R9 write error", reg_rdata, ew(0,0,1,0,0,1,1,3));
    wr(ACK);

    // R10: ack aborts a busy channel
    go();
    wr(ACK);
    chk("R10 abort", reg_rdata, ew(0,0,0,0,0,0,1,3));

    // R11: ack and final beat in the same cycle, old error present
    wr(32'h0010_0000);
    chk("R3 ce before collision", reg_rdata, ew(1,0,0,0,0,0,1,3));
    wr(32'h1);
    go();
    irq_en = 1'b1;
    reg_wr = 1'b1; reg_wdata = ACK; beat_done = 1'b1;
    step();
    reg_wr = 1'b0; beat_done = 1'b0;
    chk("R11 ack with final beat", reg_rdata, ew(0,0,0,0,0,1,1,0));
    chk("R12 irq on collision", {31'b0, irq}, 32'h1);

    // R11: ack with a read error in the same cycle
    wr(ACK);
    wr(32'h2); go();
    reg_wr = 1'b1; reg_wdata = ACK; rd_err = 1'b1;
    step();
    reg_wr = 1'b0; rd_err = 1'b0;
    chk("R11 ack with read error", reg_rdata, ew(0,1,0,0,0,1,1,2));
    irq_en = 1'b0;
    wr(ACK);
    chk("R12 irq cleared", {31'b0, irq}, 32'h0);

    finish_run();
  end

endmodule